// File: doc/BRIEF.md
# Level-Encoded Dual-Rail to Return-to-Zero Input Converter

This block sits at the input edge of a local function block. It takes a parallel bus in which every bit travels on two wires, a value wire and a phase-marking wire, and where each new word flips exactly one wire of every bit. It turns that bus into a one-hot, return-to-zero pair per bit, in which a true wire and a false wire are both low between words. A level enable from the surrounding controller chooses between the evaluate level, where the pairs carry the incoming values, and the spacer level, where every pair is held low and the incoming values are blocked.

The block also decides when a whole new word is present. The phase of each bit is the exclusive-or of its two wires. The word phase moves only when every bit shows the same phase, and holds its old value while some bits have moved and others have not. The controller uses a change of this signal as its request for new data. The block is modelled as clocked logic: every output is registered, and an input present before a rising edge shows at the outputs just after that edge.

Top module: `ledr_rz_converter`

## Requirements
- R1: While reset (rstN low) is asserted, every trueRail and falseRail bit is 0 and wordPhase is 0 (even).
- R2: The phase of a bit is ledrData XOR ledrParity. Equal wires mean even (0) and differing wires mean odd (1).
- R3: When every bit is odd at a rising edge, wordPhase is 1 after that edge.
- R4: When the bits do not all share one phase at a rising edge, wordPhase keeps its previous value, so a partial update never moves it.
- R5: When every bit is even at a rising edge, wordPhase is 0 after that edge.
- R6: When evalEn is 1 at a rising edge, after that edge trueRail equals the ledrData sampled there and falseRail equals its bitwise inverse.
- R7: When evalEn is 0 at a rising edge, every rail bit is 0 after that edge, whatever ledrData holds.
- R8: No bit ever has trueRail and falseRail high at the same time.
- R9: In evaluate, the parity wire has no effect on the rails. The value comes from ledrData alone in both phases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rstN | input | 1 | Active-low synchronous reset |
| ledrData | input | WIDTH | Value wire of each incoming bit |
| ledrParity | input | WIDTH | Phase-marking wire of each incoming bit |
| evalEn | input | 1 | 1 selects evaluate, 0 selects spacer |
| trueRail | output | WIDTH | High when the bit evaluates to 1 |
| falseRail | output | WIDTH | High when the bit evaluates to 0 |
| wordPhase | output | 1 | Completed word phase, 0 even and 1 odd |

## Verification
The assertions check on every cycle that the two rails of a bit are never both high, that the spacer level clears every pair, that an evaluate edge copies the sampled value wires, and that the word phase follows the all-odd and all-even cases and holds when the bits disagree. Only the bench's scenarios can show that a legal stream of words, each of which flips one wire per bit, makes the word phase alternate once per completed word. The same applies to a word that arrives in pieces, which must leave the phase alone until its last bit lands, and to the reset values. The bench also shows that parity-only changes leave evaluated outputs alone.

// File: rtl/ledr_rz_pkg.sv
package ledr_rz_pkg;
  typedef struct packed {
    logic evaluate;
    logic phaseOdd;
  } ctrlStrobes_t;
endpackage

// File: rtl/ledr_rz_control.sv
module ledr_rz_control
  import ledr_rz_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] ledrData,
  input  logic [WIDTH-1:0] ledrParity,
  input  logic             evalEn,
  output ctrlStrobes_t     strobes,
  output logic             wordPhase
);
  logic [WIDTH-1:0] bitPhase;
  logic allOdd;
  logic allEven;
  logic phaseQ;

  // per-bit phase: a single XOR of the two wires
  for (genvar b = 0; b < WIDTH; b++) begin : gPhase
    assign bitPhase[b] = ledrData[b] ^ ledrParity[b];
  end

  assign allOdd  = &bitPhase;
  assign allEven = ~|bitPhase;

  // word phase behaves like a C-element tree: move on agreement, else hold
  always_ff @(posedge clk) begin
    if (!rstN) begin
      phaseQ <= 1'b0;
    end else if (allOdd) begin
      phaseQ <= 1'b1;
    end else if (allEven) begin
      phaseQ <= 1'b0;
    end
  end

  assign strobes.evaluate = evalEn;
  assign strobes.phaseOdd = phaseQ;
  assign wordPhase        = phaseQ;

  assert_phase_odd_R3: assert property (@(posedge clk) disable iff (!rstN)
    (&(ledrData ^ ledrParity)) |=> phaseQ);

  assert_phase_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    ((|(ledrData ^ ledrParity)) && !(&(ledrData ^ ledrParity))) |=> $stable(phaseQ));

  assert_phase_even_R5: assert property (@(posedge clk) disable iff (!rstN)
    (~|(ledrData ^ ledrParity)) |=> !phaseQ);
endmodule

// File: rtl/ledr_rz_datapath.sv
module ledr_rz_datapath
  import ledr_rz_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] ledrData,
  input  ctrlStrobes_t     strobes,
  output logic [WIDTH-1:0] trueRail,
  output logic [WIDTH-1:0] falseRail
);
  logic [WIDTH-1:0] trueQ;
  logic [WIDTH-1:0] falseQ;

  for (genvar b = 0; b < WIDTH; b++) begin : gRail
    always_ff @(posedge clk) begin
      if (!rstN) begin
        trueQ[b]  <= 1'b0;
        falseQ[b] <= 1'b0;
      end else begin
        trueQ[b]  <= strobes.evaluate &  ledrData[b];
        falseQ[b] <= strobes.evaluate & ~ledrData[b];
      end
    end
  end

  assign trueRail  = trueQ;
  assign falseRail = falseQ;

  assert_exclusive_R8: assert property (@(posedge clk) disable iff (!rstN)
    (trueQ & falseQ) == '0);

  assert_spacer_R7: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.evaluate |=> (trueQ == '0 && falseQ == '0));

  assert_evaluate_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobes.evaluate |=> (trueQ == $past(ledrData) && falseQ == ~$past(ledrData)));
endmodule

// File: rtl/ledr_rz_converter.sv
module ledr_rz_converter
  import ledr_rz_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] ledrData,
  input  logic [WIDTH-1:0] ledrParity,
  input  logic             evalEn,
  output logic [WIDTH-1:0] trueRail,
  output logic [WIDTH-1:0] falseRail,
  output logic             wordPhase
);
  ctrlStrobes_t strobes;

  ledr_rz_control #(.WIDTH(WIDTH)) uControl (
    .clk(clk), .rstN(rstN), .ledrData(ledrData), .ledrParity(ledrParity),
    .evalEn(evalEn), .strobes(strobes), .wordPhase(wordPhase)
  );

  ledr_rz_datapath #(.WIDTH(WIDTH)) uDatapath (
    .clk(clk), .rstN(rstN), .ledrData(ledrData), .strobes(strobes),
    .trueRail(trueRail), .falseRail(falseRail)
  );
endmodule

// File: tb/ledr_rz_converter_test.sv
module ledr_rz_converter_test;
  localparam int W = 8;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [W-1:0] dRail = '0;
  logic [W-1:0] pRail = '0;
  logic en = 1'b1;
  logic [W-1:0] trueRail, falseRail;
  logic wordPhase;
  int checks = 0;
  int errors = 0;
  logic modelPhase = 1'b0;

  always #4 clk = ~clk;

  ledr_rz_converter #(.WIDTH(W)) uut (
    .clk(clk), .rstN(rstN), .ledrData(dRail), .ledrParity(pRail), .evalEn(en),
    .trueRail(trueRail), .falseRail(falseRail), .wordPhase(wordPhase)
  );

  function automatic logic nextPhase(logic old, logic [W-1:0] ph);
    if (&ph) return 1'b1;
    if (~|ph) return 1'b0;
    return old;
  endfunction

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive at falling edge, sample just after the next rising edge
  task automatic apply(logic [W-1:0] d, logic [W-1:0] p, logic e, string tag);
    @(negedge clk);
    dRail = d; pRail = p; en = e;
    @(posedge clk);
    #1;
    modelPhase = nextPhase(modelPhase, d ^ p);
    check({tag, " R6/R7 true"}, trueRail, e ? d : '0);
    check({tag, " R6/R7 false"}, falseRail, e ? ~d : '0);
    check({tag, " R8 exclusive"}, trueRail & falseRail, '0);
    check({tag, " R2 phase"}, {{(W-1){1'b0}}, wordPhase}, {{(W-1){1'b0}}, modelPhase});
  endtask

  // legal LEDR step on masked bits: new value, phase flips
  task automatic send(logic [W-1:0] v, logic [W-1:0] mask, logic e, string tag);
    logic [W-1:0] ph, nd, np;
    ph = ~(dRail ^ pRail);
    nd = (dRail & ~mask) | (v & mask);
    np = (pRail & ~mask) | ((v ^ ph) & mask);
    apply(nd, np, e, tag);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    process::self().srandom(32'd1234);
    dRail = 8'hA5; pRail = 8'h0F; en = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset true", trueRail, '0);
    check("R1 reset false", falseRail, '0);
    check("R1 reset phase", {7'b0, wordPhase}, '0);
    @(negedge clk); rstN = 1'b1;
    apply('0, '0, 1'b1, "start R5");
    // R3: full odd word
    send(8'h3C, '1, 1'b1, "full R3");
    check("R3 odd", {7'b0, wordPhase}, 8'd1);
    // R4: partial updates hold the phase
    send(8'h11, 8'h0F, 1'b1, "partial R4");
    check("R4 hold", {7'b0, wordPhase}, 8'd1);
    send(8'hF0, 8'h30, 1'b0, "partial spacer R4 R7");
    check("R4 hold2", {7'b0, wordPhase}, 8'd1);
    send(8'hF0, 8'hC0, 1'b1, "finish R5");
    check("R5 even", {7'b0, wordPhase}, 8'd0);
    // R9: parity-only change in evaluate
    apply(dRail, ~pRail, 1'b1, "parity R9");
    apply(dRail, pRail ^ 8'h55, 1'b1, "parity R9 partial R4");
    // R7: spacer with all-ones and all-zeros data
    apply(8'hFF, 8'hFF, 1'b0, "spacer R7");
    apply(8'h00, 8'hFF, 1'b0, "spacer R7 R3");
    for (int i = 0; i < 400; i++) begin
      logic [W-1:0] v, m;
      v = W'($urandom);
      m = ($urandom_range(0, 2) == 0) ? W'($urandom) : '1;
      send(v, m, 1'($urandom_range(0, 3) != 0), "random R2 R3 R4 R5 R6 R7 R8");
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule